// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32x32 two-colour cursor over a raster pixel stream. A small register interface holds the cursor's top-left position, one mask word and one colour-select word per cursor row, and a free-form control word. On the pixel side the block receives the current raster x and y, the line width and the underlying 24-bit pixel. It returns either that pixel or one of two overlay colours. The overlay colours are supplied as inputs by the palette logic that surrounds the block.

A cursor row word is read most-significant bit first, so bit 31 covers the leftmost cursor column. A set mask bit replaces the pixel. The colour bit in the same position then selects overlay colour 1 (palette slot 259) when it is 1, or overlay colour 0 (palette slot 258) when it is 0. The result is registered, so it appears one cycle after the pixel is presented. A valid flag travels with it. Timing generation and the palette itself belong to neighbouring blocks.

Top module: `hw_cursor_overlay`

## Requirements
- R1: A write to offset 0x8FC loads cursor x from data bits 31:16 and cursor y from data bits 15:0.
- R2: Writes in the range 0x900 to 0x97F load the mask word of cursor row (offset-0x900)>>2.
- R3: Writes in the range 0x980 to 0x9FF load the colour word of cursor row (offset-0x980)>>2.
- R4: Within a row word, bit 31 belongs to cursor column 0 (x = cursor x), and column c uses bit 31-c.
- R5: Where the mask bit is 1, the output is overlayColor1 if the colour bit is 1 and overlayColor0 if it is 0. Where the mask bit is 0, pixIn passes through unchanged.
- R6: Only raster rows from cursor y to cursor y+31 can be overlaid. Every other row passes through.
- R7: Nothing is drawn when cursor x is not below lineWidth. Pixels with x at or above lineWidth always pass through.
- R8: A read at offset 0x818 returns the stored control word with bit 25 forced to 1. A read at any other offset returns 0.
- R9: Reset places the cursor at x = y = 0xF000 and clears the control word, the mask words and the colour words.
- R10: outPixel and outValid are registered: they reflect the pixel inputs presented one clock earlier, with outValid equal to the earlier pixValid.
- R11: A register write applies from the pixel cycle that follows it. A pixel presented in the same cycle as the write still uses the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| lineWidth | input | 16 | Active pixels per line |
| pixValid | input | 1 | Pixel inputs valid |
| pixX | input | 16 | Raster x of the current pixel |
| pixY | input | 16 | Raster y of the current pixel |
| pixIn | input | 24 | Underlying pixel |
| overlayColor0 | input | 24 | Cursor colour for colour bit 0 (palette slot 258) |
| overlayColor1 | input | 24 | Cursor colour for colour bit 1 (palette slot 259) |
| outValid | output | 1 | Output pixel valid |
| outPixel | output | 24 | Merged output pixel |

## Verification
The off-screen property assumes that, until the first position write, no pixel with y at or above 0xF000 is presented. The parked cursor sits at that y, so such a pixel could legitimately be overlaid. The bench uses raster coordinates below 64 throughout. The clipping property assumes lineWidth does not change while a pixel is in flight, and the bench changes it only between sweeps. The sweeps place the cursor so that its box straddles the line width, sits at the origin, and starts exactly at the line width.

// File: rtl/curov_pkg.sv
package curov_pkg;
  localparam int CUR_N   = 32;
  localparam int ROW_W   = $clog2(CUR_N);
  localparam int COORD_W = 16;
  localparam int PIX_W   = 24;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int SPAN_B  = CUR_N * 4;

  localparam logic [ADDR_W-1:0] OFS_MISC = 12'h818;
  localparam logic [ADDR_W-1:0] OFS_POS  = 12'h8FC;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h900;
  localparam logic [ADDR_W-1:0] OFS_BITS = 12'h980;

  localparam logic [COORD_W-1:0] PARK_POS  = 16'hF000;
  localparam int                 MISC_ONE  = 25;

  typedef struct packed {
    logic             posWr;
    logic             maskWr;
    logic             bitsWr;
    logic [ROW_W-1:0] row;
  } curStrobe_t;
endpackage

// File: rtl/curov_ctrl.sv
module curov_ctrl
  import curov_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output curStrobe_t        strobe
);
  localparam logic [ADDR_W:0] MASK_LO = {1'b0, OFS_MASK};
  localparam logic [ADDR_W:0] MASK_HI = {1'b0, OFS_MASK} + (ADDR_W+1)'(SPAN_B);
  localparam logic [ADDR_W:0] BITS_LO = {1'b0, OFS_BITS};
  localparam logic [ADDR_W:0] BITS_HI = {1'b0, OFS_BITS} + (ADDR_W+1)'(SPAN_B);

  logic [DATA_W-1:0] miscQ;
  logic [ADDR_W:0]   addrX;
  logic              inMask, inBits;
  logic [ADDR_W-1:0] relOfs;

  always_comb begin
    addrX  = {1'b0, regAddr};
    inMask = (addrX >= MASK_LO) && (addrX < MASK_HI);
    inBits = (addrX >= BITS_LO) && (addrX < BITS_HI);
    relOfs = inBits ? (regAddr - OFS_BITS) : (regAddr - OFS_MASK);
  end

  always_comb begin
    strobe.posWr  = regWrEn && (regAddr == OFS_POS);
    strobe.maskWr = regWrEn && inMask;
    strobe.bitsWr = regWrEn && inBits;
    strobe.row    = relOfs[ROW_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) miscQ <= '0;
    else if (regWrEn && (regAddr == OFS_MISC)) miscQ <= regWrData;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == OFS_MISC) begin
      regRdData = miscQ;
      regRdData[MISC_ONE] = 1'b1;
    end
  end
endmodule

// File: rtl/curov_dp.sv
module curov_dp
  import curov_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  curStrobe_t         strobe,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [COORD_W-1:0] lineWidth,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [PIX_W-1:0]   pixIn,
  input  logic [PIX_W-1:0]   overlayColor0,
  input  logic [PIX_W-1:0]   overlayColor1,
  output logic               outValid,
  output logic [PIX_W-1:0]   outPixel
);
  localparam logic [COORD_W:0] BOX = (COORD_W+1)'(CUR_N);
  localparam logic [ROW_W-1:0] LAST_COL = ROW_W'(CUR_N - 1);

  logic [COORD_W-1:0] curX, curY;
  logic [CUR_N-1:0]   maskRow [CUR_N];
  logic [CUR_N-1:0]   bitsRow [CUR_N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curX <= PARK_POS;
      curY <= PARK_POS;
    end else if (strobe.posWr) begin
      curX <= regWrData[2*COORD_W-1:COORD_W];
      curY <= regWrData[COORD_W-1:0];
    end
  end

  for (genvar r = 0; r < CUR_N; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskRow[r] <= '0;
        bitsRow[r] <= '0;
      end else begin
        if (strobe.maskWr && (strobe.row == ROW_W'(r))) maskRow[r] <= regWrData[CUR_N-1:0];
        if (strobe.bitsWr && (strobe.row == ROW_W'(r))) bitsRow[r] <= regWrData[CUR_N-1:0];
      end
    end
  end

  logic [COORD_W:0]   dx, dy;
  logic               rowHit, colHit, clipOk;
  logic [ROW_W-1:0]   rowIdx, colIdx;
  logic               maskBit, colourBit;
  logic [PIX_W-1:0]   mergedPix;

  always_comb begin
    dx        = {1'b0, pixX} - {1'b0, curX};
    dy        = {1'b0, pixY} - {1'b0, curY};
    rowHit    = (pixY >= curY) && (dy < BOX);
    colHit    = (pixX >= curX) && (dx < BOX);
    clipOk    = (curX < lineWidth) && (pixX < lineWidth);
    rowIdx    = dy[ROW_W-1:0];
    colIdx    = LAST_COL - dx[ROW_W-1:0];
    maskBit   = maskRow[rowIdx][colIdx];
    colourBit = bitsRow[rowIdx][colIdx];
    mergedPix = pixIn;
    if (rowHit && colHit && clipOk && maskBit)
      mergedPix = colourBit ? overlayColor1 : overlayColor0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPixel <= '0;
    end else begin
      outValid <= pixValid;
      outPixel <= mergedPix;
    end
  end
endmodule

// File: rtl/hw_cursor_overlay.sv
module hw_cursor_overlay
  import curov_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [COORD_W-1:0] lineWidth,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] pixX,
  input  logic [COORD_W-1:0] pixY,
  input  logic [PIX_W-1:0]   pixIn,
  input  logic [PIX_W-1:0]   overlayColor0,
  input  logic [PIX_W-1:0]   overlayColor1,
  output logic               outValid,
  output logic [PIX_W-1:0]   outPixel
);
  curStrobe_t strobe;

  curov_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe)
  );

  curov_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .lineWidth(lineWidth), .pixValid(pixValid), .pixX(pixX), .pixY(pixY),
    .pixIn(pixIn), .overlayColor0(overlayColor0), .overlayColor1(overlayColor1),
    .outValid(outValid), .outPixel(outPixel)
  );
endmodule

// File: rtl/curov_checker.sv
module curov_checker
  import curov_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic [DATA_W-1:0]  regRdData,
  input logic [COORD_W-1:0] lineWidth,
  input logic               pixValid,
  input logic [COORD_W-1:0] pixX,
  input logic [COORD_W-1:0] pixY,
  input logic [PIX_W-1:0]   pixIn,
  input logic [PIX_W-1:0]   overlayColor0,
  input logic [PIX_W-1:0]   overlayColor1,
  input logic               outValid,
  input logic [PIX_W-1:0]   outPixel
);
  logic posSeen;
  always_ff @(posedge clk) begin
    if (!rstN) posSeen <= 1'b0;
    else if (regWrEn && regAddr == OFS_POS) posSeen <= 1'b1;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);                                             // R10
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);                                           // R10
  AST_CTRL_BIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFS_MISC) |-> regRdData[MISC_ONE]);                     // R8
  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != OFS_MISC) |-> (regRdData == '0));                       // R8
  AST_PARKED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (!posSeen && pixValid && pixY < PARK_POS) |=> (outPixel == $past(pixIn))); // R9
  AST_CLIP_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixX >= lineWidth && $stable(lineWidth)) |=> (outPixel == $past(pixIn))); // R7
endmodule

bind hw_cursor_overlay curov_checker u_chk (.*);

// File: tb/hw_cursor_overlay_tb.sv
`timescale 1ns/1ps
module hw_cursor_overlay_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [11:0] regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [15:0] lineWidth;
  logic        pixValid;
  logic [15:0] pixX, pixY;
  logic [23:0] pixIn;
  logic [23:0] overlayColor0, overlayColor1;
  logic        outValid;
  logic [23:0] outPixel;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] mMask [32];
  logic [31:0] mBits [32];
  int          mX, mY;

  always #2.5 clk = ~clk;

  hw_cursor_overlay u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 12'h000;
  endtask

  function automatic logic [23:0] pat(input int x, input int y);
    return {x[7:0], y[7:0], 8'h3C};
  endfunction

  function automatic logic [23:0] model(input int x, input int y);
    int c, r;
    if (mX < int'(lineWidth) && x < int'(lineWidth) && x >= mX && x < mX + 32 &&
        y >= mY && y < mY + 32) begin
      c = x - mX; r = y - mY;
      if (mMask[r][31-c]) return mBits[r][31-c] ? overlayColor1 : overlayColor0;
    end
    return pat(x, y);
  endfunction

  task automatic loadShape(input int salt);
    for (int r = 0; r < 32; r++) begin
      mMask[r] = ~(32'h1 << r) ^ {r[4:0], 27'h0} ^ (32'h0F0F_0F0F * salt);
      mBits[r] = 32'hA5A5_A5A5 ^ (32'h0101_0101 * r) ^ (32'h3333_0000 * salt);
      regWrite(12'h900 + 12'(r * 4), mMask[r]);  // R2
      regWrite(12'h980 + 12'(r * 4), mBits[r]);  // R3
    end
  endtask

  task automatic sweep(input int cx, input int cy, input int lw);
    string tag;
    lineWidth = 16'(lw);
    mX = cx; mY = cy;
    regWrite(12'h8FC, {16'(cx), 16'(cy)});       // R1
    for (int y = 0; y < 46; y++) begin
      for (int x = 0; x < 46; x++) begin
        @(negedge clk);
        pixValid = 1'b1; pixX = 16'(x); pixY = 16'(y); pixIn = pat(x, y);
        @(negedge clk);
        if (y < cy || y >= cy + 32)             tag = "R6";
        else if (x >= lw || cx >= lw)           tag = "R7";
        else if (x >= cx && x < cx + 32)        tag = "R4/R5";
        else                                    tag = "R5";
        check(tag, {8'h0, outPixel}, {8'h0, model(x, y)});
      end
    end
    pixValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    lineWidth = 16'd1024; pixValid = 1'b0; pixX = '0; pixY = '0; pixIn = '0;
    overlayColor0 = 24'hC0C0C0; overlayColor1 = 24'hFEDC01;
    repeat (3) @(negedge clk);
    check("R10", {31'h0, outValid}, 32'h0);
    rstN = 1'b1;

    // R9: control word cleared, cursor parked off screen
    regAddr = 12'h818; #1;
    check("R9", regRdData, 32'h0200_0000);
    @(negedge clk);
    pixValid = 1'b1; pixX = 16'd0; pixY = 16'd0; pixIn = 24'h123456;
    @(negedge clk);
    check("R9", {8'h0, outPixel}, 32'h0012_3456);
    check("R10", {31'h0, outValid}, 32'h1);
    pixValid = 1'b0;
    @(negedge clk);
    check("R10", {31'h0, outValid}, 32'h0);

    // R8: control word readback and other offsets
    regWrite(12'h818, 32'h0000_00A5);
    regAddr = 12'h818; #1;
    check("R8", regRdData, 32'h0200_00A5);
    regAddr = 12'h8FC; #1;
    check("R8", regRdData, 32'h0);
    regAddr = 12'h904; #1;
    check("R8", regRdData, 32'h0);
    regAddr = 12'h000;

    // R11: pixel presented with the write sees old state, next one sees new
    regWrite(12'h900, 32'h8000_0000);
    regWrite(12'h980, 32'h8000_0000);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 12'h8FC; regWrData = {16'd4, 16'd3};
    pixValid = 1'b1; pixX = 16'd4; pixY = 16'd3; pixIn = 24'h0A0B0C;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 12'h000;
    check("R11", {8'h0, outPixel}, 32'h000A_0B0C);
    @(negedge clk);
    check("R11", {8'h0, outPixel}, {8'h0, overlayColor1});
    pixValid = 1'b0;

    // Sweeps: straddling the line width, at the origin, starting at the width
    loadShape(1);
    sweep(10, 5, 30);
    loadShape(2);
    sweep(0, 0, 20);
    sweep(25, 12, 25);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule